// File: doc/BRIEF.md
# Nested Fixed-Priority Interrupt Controller

This block sits between five interrupt request lines and a CPU core. One line is non-maskable and ranks above everything; the other four are maskable and ranked beneath it in a fixed order. Each cycle the controller picks the most important request that is allowed through. It drives a single request to the core, together with a 3-bit source code and an 8-bit vector address.

The core accepts the request with an acknowledge pulse. The controller then records the source as in service and turns off the global enable for maskable lines. While a level is in service, requests at that level or below are held back, but a more important request can still break in and nest. An end-of-service pulse retires the most important level in service, so the lower levels come back in order.

The top maskable line is captured on its rising edge and held until it is accepted or cleared by software. The other three maskable lines are plain levels. The non-maskable line needs a rising edge and must then stay high until it is accepted.

Top module: `pic_nest_ctrl`

## Requirements
- R1: Source codes rank 4 (non-maskable) above 3 (edge line, `mreq_i[3]`), 3 above 2 (`mreq_i[2]`), 2 above 1 (`mreq_i[1]`), and 1 above 0 (`mreq_i[0]`). When several sources are eligible at once, the highest code is presented.
- R2: The non-maskable source is presented even when every mask bit is set and the global enable is off.
- R3: A maskable source is never presented while its mask bit (bit n of the mask, written through `mask_wd_i` when `mask_we_i` is high) is 1, or while the global enable is off. `en_set_i` sets the enable and `en_clr_i` clears it.
- R4: The non-maskable request becomes pending one cycle after a low-to-high change on `nmi_i`, and only while the line stays high. Dropping the line cancels it. A line held high after acceptance raises no further request until a new rising edge.
- R5: A rising edge on `mreq_i[3]` is latched, so the request stays pending after the line falls. It is removed by acceptance of source 3 or by `edge_clr_i`.
- R6: Sources 2, 1 and 0 follow their input level in the same cycle; when the line falls, the request is gone.
- R7: While any level is in service, requests at that level or lower are not presented, and a higher level may still be presented.
- R8: `ack_i` while `int_req_o` is high sets `in_svc_o[int_src_o]` and clears the global enable. An `ack_i` while no request is shown has no effect.
- R9: `eos_i` clears the highest set bit of `in_svc_o` and leaves the other bits unchanged.
- R10: Vectors are 0x24 for source 4, 0x3C for source 3, 0x34 for source 2 and 0x2C for source 1. Source 0 carries vector 0x00.
- R11: After reset there is no request, nothing is in service, the global enable is off and all mask bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request line |
| mreq_i | input | 4 | Maskable request lines; bit 3 is edge-captured |
| mask_we_i | input | 1 | Load the mask register |
| mask_wd_i | input | 4 | New mask value, 1 = blocked |
| en_set_i | input | 1 | Turn the global enable on |
| en_clr_i | input | 1 | Turn the global enable off |
| edge_clr_i | input | 1 | Drop the captured edge request |
| ack_i | input | 1 | Core accepts the presented request |
| eos_i | input | 1 | End of service for the top active level |
| int_req_o | output | 1 | Request to the core |
| int_src_o | output | 3 | Presented source code |
| int_vec_o | output | 8 | Presented vector address |
| in_svc_o | output | 5 | In-service bit per source code |

## Verification
The ranking is tried several ways. All three level lines are raised together and then taken away one at a time, which tells a correct encoder from one that picks the lowest source or the first source it finds. Level lines are driven against mask writes and enable toggles to separate the mask check from the enable check, and the non-maskable line is driven with everything masked. Nesting is tested by accepting a low source, raising equal, lower and higher sources, and then retiring levels one at a time. This shows whether blocking compares against the right level and whether end-of-service clears the top bit rather than the bottom one. The edge line is pulsed and then cleared by software, and the non-maskable line is held, re-raised and dropped early, so that latch behaviour can be told apart from level behaviour.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // Vector address for a given source code. The top source uses its own
  // address, source 0 has none, and the rest sit on a fixed stride.
  function automatic logic [7:0] vec_of(input int src, input int top,
                                        input logic [7:0] top_vec,
                                        input logic [7:0] base,
                                        input logic [7:0] step);
    logic [7:0] v;
    if (src == top)      v = top_vec;
    else if (src == 0)   v = 8'h00;
    else                 v = base + 8'(step * src);
    return v;
  endfunction

endpackage

// File: rtl/pic_edge_cap.sv
module pic_edge_cap #(
  parameter bit HOLD_LEVEL = 1'b0  // 1: the line must stay high to remain pending
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);

  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic rise;

  assign rise   = line_i & ~prev_q;
  assign prev_d = line_i;

  generate
    if (HOLD_LEVEL) begin : g_hold
      always_comb begin
        flag_d = (flag_q | rise) & line_i & ~clr_i;
      end
      assign pend_o = flag_q & line_i;
    end else begin : g_latch
      always_comb begin
        flag_d = (flag_q & ~clr_i) | rise;
      end
      assign pend_o = flag_q;

      // R5: a captured edge stays until it is cleared
      assert_latch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/pic_gate.sv
module pic_gate #(
  parameter int NUM_LVL = 5,
  localparam int NM     = NUM_LVL - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] raw_pend_i,
  input  logic               mask_we_i,
  input  logic [NM-1:0]      mask_wd_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               ack_take_i,
  output logic [NUM_LVL-1:0] elig_o
);

  logic [NM-1:0] mask_q, mask_d;
  logic          ien_q, ien_d;

  always_comb begin
    mask_d = mask_q;
    if (mask_we_i) mask_d = mask_wd_i;
    ien_d = ien_q;
    if (en_set_i)   ien_d = 1'b1;
    if (en_clr_i)   ien_d = 1'b0;
    if (ack_take_i) ien_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ien_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ien_q  <= ien_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_mask
      assign elig_o[g] = raw_pend_i[g] & ~mask_q[g] & ien_q;
    end
  endgenerate
  assign elig_o[NM] = raw_pend_i[NM];

  // R8: acceptance turns the global enable off
  assert_ack_drops_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take_i |=> !ien_q);

endmodule

// File: rtl/pic_prio_sel.sv
module pic_prio_sel #(
  parameter int NUM_LVL = 5,
  localparam int SRC_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] elig_i,
  input  logic [NUM_LVL-1:0] svc_i,
  output logic               req_o,
  output logic [SRC_W-1:0]   src_o
);

  logic [NUM_LVL-1:0] blocked;

  genvar g;
  generate
    for (g = 0; g < NUM_LVL; g++) begin : g_block
      assign blocked[g] = |svc_i[NUM_LVL-1:g];
    end
  endgenerate

  always_comb begin
    req_o = 1'b0;
    src_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (elig_i[l] && !blocked[l]) begin
        req_o = 1'b1;
        src_o = SRC_W'(l);
      end
    end
  end

  // R1: only an eligible source is ever presented
  assert_src_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> elig_i[src_o]);

endmodule

// File: rtl/pic_svc_track.sv
module pic_svc_track #(
  parameter int NUM_LVL = 5,
  localparam int SRC_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eos_i,
  input  logic               set_i,
  input  logic [SRC_W-1:0]   set_idx_i,
  output logic [NUM_LVL-1:0] svc_o
);

  logic [NUM_LVL-1:0] svc_q, svc_d;
  logic [NUM_LVL-1:0] top_bit;

  always_comb begin
    top_bit = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (svc_q[i]) top_bit = NUM_LVL'(1) << i;
    end
  end

  always_comb begin
    svc_d = svc_q;
    if (eos_i) svc_d = svc_d & ~top_bit;
    if (set_i) svc_d[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign svc_o = svc_q;

  // R9: end of service retires exactly one level
  assert_eos_one_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_i && !set_i && svc_q != '0) |=>
      ($countones(svc_q) == $countones($past(svc_q)) - 1));

  // R9: the retired level is the highest one, lower ones survive
  assert_eos_keeps_lower_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_i && !set_i && $countones(svc_q) > 1) |=> (svc_q != '0));

endmodule

// File: rtl/pic_nest_ctrl.sv
module pic_nest_ctrl #(
  parameter int          NUM_MASKABLE = 4,
  parameter int          VEC_W        = 8,
  parameter logic [7:0]  VEC_TOP      = 8'h24,
  parameter logic [7:0]  VEC_BASE     = 8'h24,
  parameter logic [7:0]  VEC_STEP     = 8'h08,
  localparam int         NUM_LVL      = NUM_MASKABLE + 1,
  localparam int         SRC_W        = $clog2(NUM_LVL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    nmi_i,
  input  logic [NUM_MASKABLE-1:0] mreq_i,
  input  logic                    mask_we_i,
  input  logic [NUM_MASKABLE-1:0] mask_wd_i,
  input  logic                    en_set_i,
  input  logic                    en_clr_i,
  input  logic                    edge_clr_i,
  input  logic                    ack_i,
  input  logic                    eos_i,
  output logic                    int_req_o,
  output logic [SRC_W-1:0]        int_src_o,
  output logic [VEC_W-1:0]        int_vec_o,
  output logic [NUM_LVL-1:0]      in_svc_o
);

  import pic_pkg::*;

  localparam logic [SRC_W-1:0] SRC_NMI  = SRC_W'(NUM_MASKABLE);
  localparam logic [SRC_W-1:0] SRC_EDGE = SRC_W'(NUM_MASKABLE - 1);

  logic               ack_take;
  logic               nmi_pend;
  logic               edge_pend;
  logic [NUM_LVL-1:0] raw_pend;
  logic [NUM_LVL-1:0] elig;

  assign ack_take = ack_i & int_req_o;

  pic_edge_cap #(.HOLD_LEVEL(1'b1)) u_nmi_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (nmi_i),
    .clr_i  (ack_take && (int_src_o == SRC_NMI)),
    .pend_o (nmi_pend)
  );

  pic_edge_cap #(.HOLD_LEVEL(1'b0)) u_edge_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (mreq_i[NUM_MASKABLE-1]),
    .clr_i  (edge_clr_i || (ack_take && (int_src_o == SRC_EDGE))),
    .pend_o (edge_pend)
  );

  assign raw_pend = {nmi_pend, edge_pend, mreq_i[NUM_MASKABLE-2:0]};

  pic_gate #(.NUM_LVL(NUM_LVL)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_pend_i (raw_pend),
    .mask_we_i  (mask_we_i),
    .mask_wd_i  (mask_wd_i),
    .en_set_i   (en_set_i),
    .en_clr_i   (en_clr_i),
    .ack_take_i (ack_take),
    .elig_o     (elig)
  );

  pic_prio_sel #(.NUM_LVL(NUM_LVL)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig_i (elig),
    .svc_i  (in_svc_o),
    .req_o  (int_req_o),
    .src_o  (int_src_o)
  );

  pic_svc_track #(.NUM_LVL(NUM_LVL)) u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .eos_i     (eos_i),
    .set_i     (ack_take),
    .set_idx_i (int_src_o),
    .svc_o     (in_svc_o)
  );

  always_comb begin
    int_vec_o = '0;
    if (int_req_o)
      int_vec_o = VEC_W'(vec_of(int'(int_src_o), NUM_MASKABLE,
                                VEC_TOP, VEC_BASE, VEC_STEP));
  end

  // R2: a pending non-maskable request wins unless its own level is busy
  assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !in_svc_o[NUM_MASKABLE]) |-> (int_req_o && int_src_o == SRC_NMI));

  // R4: the non-maskable source is shown only while its line is high
  assert_nmi_line_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_o && int_src_o == SRC_NMI) |-> nmi_i);

  // R6: a level source is shown only while its line is high
  assert_level_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_o && int_src_o < SRC_EDGE) |-> mreq_i[int_src_o]);

  // R7: nothing at or below an in-service level is shown
  assert_nest_headroom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_req_o |-> (in_svc_o < (NUM_LVL'(1) << int_src_o)));

  // R8: acceptance marks the presented source as in service
  assert_ack_marks_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_req_o && !eos_i) |=> in_svc_o[$past(int_src_o)]);

endmodule

// File: tb/test_pic_nest_ctrl.sv
module test_pic_nest_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi = 1'b0;
  logic [3:0] mreq = '0;
  logic       mask_we = 1'b0;
  logic [3:0] mask_wd = '0;
  logic       en_set = 1'b0, en_clr = 1'b0, edge_clr = 1'b0;
  logic       ack = 1'b0, eos = 1'b0;
  logic       int_req;
  logic [2:0] int_src;
  logic [7:0] int_vec;
  logic [4:0] in_svc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pic_nest_ctrl i_pic_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .mreq_i(mreq),
    .mask_we_i(mask_we), .mask_wd_i(mask_wd), .en_set_i(en_set),
    .en_clr_i(en_clr), .edge_clr_i(edge_clr), .ack_i(ack), .eos_i(eos),
    .int_req_o(int_req), .int_src_o(int_src), .int_vec_o(int_vec),
    .in_svc_o(in_svc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_vec(input int s);
    case (s)
      4: return 'h24;
      3: return 'h3C;
      2: return 'h34;
      1: return 'h2C;
      default: return 0;
    endcase
  endfunction

  // Behavioural reference model, compared every cycle away from the edge
  bit       m_nprev, m_arm, m_eprev, m_lat, m_ien;
  bit [3:0] m_mask;
  bit [4:0] m_svc;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_nprev = 0; m_arm = 0; m_eprev = 0; m_lat = 0; m_ien = 0;
      m_mask = '1; m_svc = '0;
    end else begin
      int top, es;
      bit er, e, ack_t;
      top = -1;
      for (int l = 0; l < 5; l++) if (m_svc[l]) top = l;
      er = 0; es = 0;
      for (int l = 0; l < 5; l++) begin
        if (l == 4)      e = m_arm && nmi;
        else if (l == 3) e = m_lat && m_ien && !m_mask[3];
        else             e = mreq[l] && m_ien && !m_mask[l];
        if (e && l > top) begin er = 1; es = l; end
      end
      chk(int_req == er, "R1 model int_req", int_req, er);
      if (er) begin
        chk(int_src == es, "R1 model int_src", int_src, es);
        chk(int_vec == exp_vec(es), "R10 model int_vec", int_vec, exp_vec(es));
      end
      chk(in_svc == m_svc, "R8 model in_svc", in_svc, m_svc);
      ack_t = ack && er;
      m_arm = (m_arm || (nmi && !m_nprev)) && nmi && !(ack_t && es == 4);
      m_lat = (m_lat && !(edge_clr || (ack_t && es == 3))) || (mreq[3] && !m_eprev);
      if (eos && top >= 0) m_svc[top] = 0;
      if (ack_t) m_svc[es] = 1;
      if (en_set) m_ien = 1;
      if (en_clr) m_ien = 0;
      if (ack_t)  m_ien = 0;
      if (mask_we) m_mask = mask_wd;
      m_nprev = nmi; m_eprev = mreq[3];
    end
  end

  task automatic cyc();  @(posedge clk); #1; endtask
  task automatic look(); @(negedge clk); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    look();
    chk(int_req == 0, "R11 no request after reset", int_req, 0);
    chk(in_svc == 0, "R11 nothing in service after reset", in_svc, 0);
    cyc();
    mreq = 4'b0111;
    look();
    chk(int_req == 0, "R3 reset mask blocks levels", int_req, 0);
    cyc();
    en_set = 1; mask_we = 1; mask_wd = 4'b0000;
    cyc();
    en_set = 0; mask_we = 0;
    look();
    chk(int_src == 2, "R1 three levels pick top", int_src, 2);
    chk(int_vec == 'h34, "R10 vector src2", int_vec, 'h34);
    cyc();
    mreq = 4'b0011;
    look();
    chk(int_src == 1, "R1 two levels pick top", int_src, 1);
    chk(int_vec == 'h2C, "R10 vector src1", int_vec, 'h2C);
    cyc();
    mreq = 4'b0001;
    look();
    chk(int_req == 1 && int_src == 0, "R10 src0 presented", int_src, 0);
    chk(int_vec == 0, "R10 src0 has no vector", int_vec, 0);
    cyc();
    mreq = 4'b0000;
    look();
    chk(int_req == 0, "R6 level drop removes request", int_req, 0);
    cyc();
    mreq = 4'b0001; mask_we = 1; mask_wd = 4'b0001;
    cyc();
    mask_we = 0;
    look();
    chk(int_req == 0, "R3 mask bit blocks", int_req, 0);
    cyc();
    en_clr = 1; mask_we = 1; mask_wd = 4'b0000;
    cyc();
    en_clr = 0; mask_we = 0;
    look();
    chk(int_req == 0, "R3 disabled blocks", int_req, 0);
    cyc();
    en_set = 1;
    cyc();
    en_set = 0; mreq = 4'b0000;
    // R5 edge capture
    cyc();
    mreq = 4'b1000;
    cyc();
    mreq = 4'b0000;
    look();
    chk(int_req == 1 && int_src == 3, "R5 edge latched after fall", int_src, 3);
    chk(int_vec == 'h3C, "R10 vector src3", int_vec, 'h3C);
    cyc();
    look();
    chk(int_req == 1 && int_src == 3, "R5 edge still pending", int_src, 3);
    cyc();
    edge_clr = 1;
    cyc();
    edge_clr = 0;
    look();
    chk(int_req == 0, "R5 software clear", int_req, 0);
    // R8 acceptance, R9 end of service
    cyc();
    mreq = 4'b1000;
    cyc();
    mreq = 4'b0001;
    look();
    chk(int_src == 3, "R1 edge beats level", int_src, 3);
    cyc();
    ack = 1;
    cyc();
    ack = 0;
    look();
    chk(in_svc == 5'b01000, "R8 ack marks src3", in_svc, 5'b01000);
    chk(int_req == 0, "R8 ack clears enable", int_req, 0);
    cyc();
    en_set = 1;
    cyc();
    en_set = 0;
    look();
    chk(int_req == 0, "R7 lower blocked by src3", int_req, 0);
    cyc();
    eos = 1;
    cyc();
    eos = 0;
    look();
    chk(in_svc == 0, "R9 eos clears src3", in_svc, 0);
    chk(int_req == 1 && int_src == 0, "R9 lower level returns", int_src, 0);
    cyc();
    mreq = 4'b0010;
    look();
    chk(int_src == 1, "R7 src1 before nesting", int_src, 1);
    cyc();
    ack = 1;
    cyc();
    ack = 0;
    en_set = 1;
    cyc();
    en_set = 0;
    look();
    chk(int_req == 0, "R7 equal level blocked", int_req, 0);
    cyc();
    mreq = 4'b0011;
    look();
    chk(int_req == 0, "R7 lower level blocked", int_req, 0);
    cyc();
    mreq = 4'b0110;
    look();
    chk(int_req == 1 && int_src == 2, "R7 higher level preempts", int_src, 2);
    cyc();
    ack = 1;
    cyc();
    ack = 0; mreq = 4'b0000;
    look();
    chk(in_svc == 5'b00110, "R8 nested in service", in_svc, 5'b00110);
    cyc();
    eos = 1;
    cyc();
    eos = 0;
    look();
    chk(in_svc == 5'b00010, "R9 highest retired first", in_svc, 5'b00010);
    cyc();
    eos = 1;
    cyc();
    eos = 0;
    look();
    chk(in_svc == 0, "R9 second retire", in_svc, 0);
    // R2 and R4 non-maskable line
    cyc();
    en_clr = 1; mask_we = 1; mask_wd = 4'b1111;
    cyc();
    en_clr = 0; mask_we = 0; nmi = 1;
    look();
    chk(int_req == 0, "R4 not pending on rise cycle", int_req, 0);
    cyc();
    look();
    chk(int_req == 1 && int_src == 4, "R2 nmi past mask and disable", int_src, 4);
    chk(int_vec == 'h24, "R10 vector src4", int_vec, 'h24);
    cyc();
    ack = 1;
    cyc();
    ack = 0;
    look();
    chk(in_svc == 5'b10000, "R8 nmi in service", in_svc, 5'b10000);
    cyc();
    eos = 1;
    cyc();
    eos = 0;
    look();
    chk(int_req == 0, "R4 held line no new request", int_req, 0);
    cyc();
    nmi = 0;
    cyc();
    nmi = 1;
    cyc();
    look();
    chk(int_req == 1 && int_src == 4, "R4 new rise pending", int_src, 4);
    cyc();
    nmi = 0;
    look();
    chk(int_req == 0, "R4 drop before ack cancels", int_req, 0);
    cyc();
    nmi = 1;
    cyc();
    nmi = 0;
    cyc();
    look();
    chk(int_req == 0, "R4 short pulse not held", int_req, 0);
    cyc();
    cyc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule